// File: doc/BRIEF.md
# Pipelined Look-Ahead Recursive Filter

This block is a fixed-point recursive filter whose response is that of a second-order pole pair, recast into an equivalent fourth-order form. In that form the feedback uses only the outputs two and four samples back. The newest output is therefore never needed to compute the next one, and the recursive path can hold two register stages. The feed-forward part is a five-tap direct-form-I FIR on the input history. Its taps are the original numerator multiplied by the factor that cancels the added poles.

Samples enter with a valid strobe. Each accepted sample produces exactly one output sample, two clock edges later. Samples may arrive back to back or with gaps of any length. All products are kept at full precision and summed in one wide accumulator. The sum is then requantized once, by truncating its magnitude toward zero, and clipped to the output range. The clipped value becomes both the output and the stored feedback state. All coefficients are elaboration-time parameters, computed offline. The accumulator width, data width plus coefficient width plus three, must not exceed 64.

Top module: `lookahead_iir`

## Requirements
- R1: Each output is y[n] = Q((N0·x[n] + N1·x[n-1] + N2·x[n-2] + N3·x[n-3] + N4·x[n-4] + D2·y[n-2] + D4·y[n-4]) / 2^FRAC_W), where all coefficients are signed integers carrying FRAC_W fraction bits and Q is the requantizer of R3 and R4.
- R2: An input accepted at a rising edge (in_valid high) produces a one-cycle out_valid pulse at the second rising edge after it. Every output pulse corresponds to one accepted input, in order.
- R3: If the requantized value lies above 2^(DATA_W-1)-1 or below -2^(DATA_W-1), the output and the stored state clip to that limit and never wrap.
- R4: Requantization truncates toward zero. With the default coefficients and clean state, a single input of -14 gives -1, +14 gives +1, and -1 gives 0.
- R5: Reset clears the input and output histories, drives out_valid low and drives out_data to 0.
- R6: The feedback uses the outputs of the samples two and four positions earlier in the sample sequence. This holds whether the previous sample is still in the pipeline (back-to-back inputs) or has already finished.
- R7: With zero input after any nonzero excitation, the output reaches exactly 0 and stays 0.
- R8: While out_valid is low, out_data holds the last output. The filter state does not change in cycles without in_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | DATA_W | Signed filtered sample, held between strobes |

## Verification
The assertions assume that in_valid stays low while reset is asserted. Under that assumption, the two-cycle latency check never reaches back past reset into a captured sample. They also assume the coefficients keep the accumulator within 64 bits, so the wide requantized value they compare against the clip limits is exact. The bench holds in_valid low through every reset and drives inputs only from the half-cycle point. Its stimulus includes full-scale steps of both signs so that the clip properties are actually exercised rather than passing vacuously.

// File: rtl/lai_pkg.sv
package lai_pkg;

  // Divide by 2^sh, discarding the remainder magnitude (toward zero).
  function automatic longint rtz_scale(longint a, int sh);
    if (a < 0) return -((-a) >>> sh);
    return a >>> sh;
  endfunction

  // Clip to the range of a w-bit two's-complement word.
  function automatic longint clip_to(longint v, int w);
    longint hi;
    longint lo;
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -hi - 1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/lai_x_line.sv
module lai_x_line #(
  parameter int DATA_W = 16,
  parameter int TAPS   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  output logic [TAPS*DATA_W-1:0]   x_taps
);

  // Tap k holds x[n-1-k] relative to the sample being presented.
  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        x_taps[k*DATA_W +: DATA_W] <= '0;
      end else if (in_valid) begin
        if (k == 0) x_taps[k*DATA_W +: DATA_W] <= in_data;
        else        x_taps[k*DATA_W +: DATA_W] <= x_taps[(k-1)*DATA_W +: DATA_W];
      end
    end
  end

endmodule

// File: rtl/lai_mac_stage.sv
module lai_mac_stage #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int TAPS   = 4,
  parameter int HIST   = 4,
  parameter int ACC_W  = 35,
  parameter logic signed [COEF_W-1:0] NUM0 = '0,
  parameter logic signed [COEF_W-1:0] NUM1 = '0,
  parameter logic signed [COEF_W-1:0] NUM2 = '0,
  parameter logic signed [COEF_W-1:0] NUM3 = '0,
  parameter logic signed [COEF_W-1:0] NUM4 = '0,
  parameter logic signed [COEF_W-1:0] DEN2 = '0,
  parameter logic signed [COEF_W-1:0] DEN4 = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  input  logic [TAPS*DATA_W-1:0]   x_taps,
  input  logic [HIST*DATA_W-1:0]   y_hist,
  output logic                     s1_valid,
  output logic signed [ACC_W-1:0]  s1_acc
);

  localparam logic signed [COEF_W-1:0] NUM_C [TAPS] = '{NUM1, NUM2, NUM3, NUM4};

  logic signed [DATA_W-1:0] y_back2, y_back4;
  longint                   sum;
  logic                     all_quiet;

  // When the stage register still carries a sample, the newest stored
  // output is y[n-2]; otherwise it is y[n-1] and everything shifts by one.
  always_comb begin
    if (s1_valid) begin
      y_back2 = $signed(y_hist[0*DATA_W +: DATA_W]);
      y_back4 = $signed(y_hist[2*DATA_W +: DATA_W]);
    end else begin
      y_back2 = $signed(y_hist[1*DATA_W +: DATA_W]);
      y_back4 = $signed(y_hist[3*DATA_W +: DATA_W]);
    end
  end

  always_comb begin
    sum = longint'(in_data) * longint'(NUM0);
    for (int k = 0; k < TAPS; k++)
      sum += longint'($signed(x_taps[k*DATA_W +: DATA_W])) * longint'(NUM_C[k]);
    sum += longint'(y_back2) * longint'(DEN2);
    sum += longint'(y_back4) * longint'(DEN4);
  end

  assign all_quiet = (in_data == '0) && (x_taps == '0) &&
                     (y_back2 == '0) && (y_back4 == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_acc   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) s1_acc <= ACC_W'(sum);
    end
  end

  // R7: silent input on silent state yields a zero accumulator
  assert_quiet_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && all_quiet) |=> (s1_acc == '0));

endmodule

// File: rtl/lai_quant_stage.sv
module lai_quant_stage #(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 14,
  parameter int HIST   = 4,
  parameter int ACC_W  = 35
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s1_valid,
  input  logic signed [ACC_W-1:0]  s1_acc,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_data,
  output logic [HIST*DATA_W-1:0]   y_hist
);

  localparam longint MAXV = (longint'(1) <<< (DATA_W - 1)) - 1;
  localparam longint MINV = -MAXV - 1;

  longint                   q_wide;
  logic signed [DATA_W-1:0] y_next;
  logic                     clip_hi, clip_lo;

  assign q_wide  = lai_pkg::rtz_scale(longint'(s1_acc), FRAC_W);
  assign y_next  = DATA_W'(lai_pkg::clip_to(q_wide, DATA_W));
  assign clip_hi = q_wide > MAXV;
  assign clip_lo = q_wide < MINV;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      y_hist    <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) y_hist <= {y_hist[(HIST-1)*DATA_W-1:0], y_next};
    end
  end

  assign out_data = $signed(y_hist[DATA_W-1:0]);

  // R3: overflow above full scale pins the output at the top
  assert_clip_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && clip_hi) |=> (longint'(out_data) == MAXV));
  // R3: overflow below full scale pins the output at the bottom
  assert_clip_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && clip_lo) |=> (longint'(out_data) == MINV));
  // R4: truncation toward zero never flips the sign of the sum
  assert_rtz_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> ((out_data == '0) || (out_data[DATA_W-1] == $past(s1_acc[ACC_W-1]))));
  // R8: the state is frozen when no sample moves through
  assert_state_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> $stable(y_hist));

endmodule

// File: rtl/lookahead_iir.sv
module lookahead_iir #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 14,
  parameter logic signed [COEF_W-1:0] NUM0 = 16'sd1229,
  parameter logic signed [COEF_W-1:0] NUM1 = 16'sd3932,
  parameter logic signed [COEF_W-1:0] NUM2 = 16'sd4792,
  parameter logic signed [COEF_W-1:0] NUM3 = 16'sd2703,
  parameter logic signed [COEF_W-1:0] NUM4 = 16'sd614,
  parameter logic signed [COEF_W-1:0] DEN2 = 16'sd7209,
  parameter logic signed [COEF_W-1:0] DEN4 = -16'sd4096
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_data
);

  localparam int TAPS  = 4;
  localparam int HIST  = 4;
  localparam int ACC_W = DATA_W + COEF_W + 3;

  logic [TAPS*DATA_W-1:0]  x_taps;
  logic [HIST*DATA_W-1:0]  y_hist;
  logic                    s1_valid;
  logic signed [ACC_W-1:0] s1_acc;

  lai_x_line #(.DATA_W(DATA_W), .TAPS(TAPS)) u_x_line (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .x_taps(x_taps)
  );

  lai_mac_stage #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .TAPS(TAPS), .HIST(HIST), .ACC_W(ACC_W),
    .NUM0(NUM0), .NUM1(NUM1), .NUM2(NUM2), .NUM3(NUM3), .NUM4(NUM4),
    .DEN2(DEN2), .DEN4(DEN4)
  ) u_mac (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .x_taps(x_taps), .y_hist(y_hist), .s1_valid(s1_valid), .s1_acc(s1_acc)
  );

  lai_quant_stage #(
    .DATA_W(DATA_W), .FRAC_W(FRAC_W), .HIST(HIST), .ACC_W(ACC_W)
  ) u_quant (
    .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_acc(s1_acc),
    .out_valid(out_valid), .out_data(out_data), .y_hist(y_hist)
  );

  // R2: every output pulse traces back to an input two edges earlier
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));

endmodule

// File: tb/test_lookahead_iir.sv
module test_lookahead_iir;

  localparam int DW   = 16;
  localparam int FW   = 14;
  localparam int NV   = 24;
  localparam longint B0 = 1229, B1 = 3932, B2 = 4792, B3 = 2703, B4 = 614;
  localparam longint A2 = 7209, A4 = -4096;
  localparam longint TOP = 32767, BOT = -32768;

  localparam int STIM_X [NV] = '{1000, -2000, 5000, 0, 12345, -32768, 32767, 7,
                                 -7, 300, 0, 0, 20000, 20000, -15000, 1,
                                 -1, 4096, -4096, 250, 31000, -31000, 0, 99};
  localparam int STIM_GAP [NV] = '{0, 0, 3, 0, 1, 0, 0, 5,
                                   0, 2, 0, 0, 0, 1, 0, 0,
                                   4, 0, 0, 1, 0, 0, 7, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic out_valid;
  logic signed [DW-1:0] out_data;

  int nchk = 0;
  int nbad = 0;
  int cyc = 0;
  longint mx [5];
  longint my [5];
  longint exp_y [$];
  int     exp_c [$];
  longint last_y = 0;
  int     zero_run = 0;
  int     hits_top = 0;
  int     hits_bot = 0;

  lookahead_iir #(.DATA_W(DW), .COEF_W(16), .FRAC_W(FW)) i_lookahead_iir (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < 5; k++) begin mx[k] = 0; my[k] = 0; end
    exp_y.delete();
    exp_c.delete();
  endtask

  // Integer reference: C division truncates toward zero.
  function automatic longint model_step(longint x);
    longint acc, q;
    for (int k = 4; k > 0; k--) mx[k] = mx[k-1];
    mx[0] = x;
    acc = B0*mx[0] + B1*mx[1] + B2*mx[2] + B3*mx[3] + B4*mx[4] + A2*my[2] + A4*my[4];
    q = acc / (longint'(1) << FW);
    if (q > TOP) q = TOP;
    if (q < BOT) q = BOT;
    for (int k = 4; k > 1; k--) my[k] = my[k-1];
    my[1] = q;
    return q;
  endfunction

  task automatic send(int x);
    in_valid = 1'b1;
    in_data  = DW'(x);
    exp_y.push_back(model_step(x));
    exp_c.push_back(cyc + 2);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    model_clear();
    last_y = 0;
    idle(3);
    // R5: outputs cleared while reset holds
    chk("R5 out_valid", longint'(out_valid), 0);
    chk("R5 out_data", longint'(out_data), 0);
    rst_n = 1'b1;
    idle(1);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (exp_y.size() == 0) begin
          chk("R2 unexpected output", 1, 0);
        end else begin
          chk("R1 value", longint'(out_data), exp_y.pop_front());
          chk("R2 latency", longint'(cyc), longint'(exp_c.pop_front()));
        end
        last_y = out_data;
        zero_run = (out_data == 0) ? zero_run + 1 : 0;
        if (out_data == TOP) hits_top++;
        if (out_data == BOT) hits_bot++;
      end else begin
        chk("R8 hold", longint'(out_data), last_y);
      end
    end
  end

  initial begin
    #(8 * 150000);
    chk("watchdog", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end

  initial begin
    model_clear();
    idle(4);
    chk("R5 reset out_valid", longint'(out_valid), 0);
    chk("R5 reset out_data", longint'(out_data), 0);
    rst_n = 1'b1;
    idle(1);

    // R1, R6, R8: mixed back-to-back and spaced samples against the model
    for (int i = 0; i < NV; i++) begin
      send(STIM_X[i]);
      idle(STIM_GAP[i]);
    end
    idle(4);
    chk("R2 drained", longint'(exp_y.size()), 0);

    // R5: reset in the middle of a burst discards in-flight samples
    send(9000);
    send(-9000);
    do_reset();
    send(2000);
    idle(4);
    chk("R5 fresh state", last_y, (2000 * B0) / 16384);

    // R4: truncation toward zero on tiny results
    do_reset();
    send(-14);
    idle(4);
    chk("R4 -14 gives -1", last_y, -1);
    do_reset();
    send(14);
    idle(4);
    chk("R4 +14 gives +1", last_y, 1);
    do_reset();
    send(-1);
    idle(4);
    chk("R4 -1 gives 0", last_y, 0);

    // R3: full-scale steps overshoot and must clip, not wrap
    do_reset();
    hits_top = 0;
    for (int i = 0; i < 16; i++) send(32767);
    idle(4);
    chk("R3 positive clip reached", longint'(hits_top > 0), 1);
    hits_bot = 0;
    for (int i = 0; i < 20; i++) send(-32768);
    idle(4);
    chk("R3 negative clip reached", longint'(hits_bot > 0), 1);

    // R7: zero input after heavy excitation settles to exact zero
    zero_run = 0;
    for (int i = 0; i < 60; i++) send(0);
    idle(4);
    chk("R7 settled to zero", longint'(zero_run >= 20), 1);
    idle(10);
    for (int i = 0; i < 5; i++) begin send(0); idle(2); end
    idle(4);
    chk("R7 stays zero", last_y, 0);
    chk("R7 zero run", longint'(zero_run >= 25), 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end

endmodule